// File: doc/BRIEF.md
# OUT Endpoint Transfer Tracker

This block follows the progress of one OUT transfer on a single device endpoint. Software first loads a byte budget, a packet budget and a 2-bit status field. It then arms the endpoint. While the endpoint is armed, the block alone updates these values:

- The packet budget drops by one each time a received packet is committed into the receive FIFO.
- The byte budget drops by the byte count of each packet moved out of the FIFO into memory.
- The 2-bit field records the data PID of the latest committed packet. It can also serve as a count of SETUP packets still allowed back to back.

The transfer ends when either budget reaches zero. At that point the block disarms itself and gives a one-cycle done pulse. When the byte budget is the one that empties, it also sets a sticky interrupt. Packet decoding, the FIFO and the memory mover sit outside the block and appear only as single-cycle strobes.

Top module: `oep_xfer_tracker`

## Requirements
- R1: After synchronous reset, `xfer_size`, `pkt_count`, `pid_field`, `ep_enabled`, `xfer_done` and `irq` are all zero.
- R2: A `sw_load` strobe while disarmed copies `sw_size`, `sw_pkts` and `sw_field` into `xfer_size`, `pkt_count` and `pid_field`. The new values are visible after the next clock edge.
- R3: While armed, `sw_load` and `sw_arm` have no effect on any output.
- R4: A `sw_arm` strobe while disarmed sets `ep_enabled` at the next edge, but only if both budgets are nonzero after any load in the same cycle. If either budget is zero, the strobe is ignored.
- R5: While armed, `rx_commit` lowers `pkt_count` by exactly one and stores `rx_pid` in `pid_field`. The PID codes are 00 DATA0, 01 DATA2, 10 DATA1 and 11 MDATA.
- R6: While armed, `drain_valid` lowers `xfer_size` by `drain_bytes`. A byte count larger than the remaining size leaves `xfer_size` at zero rather than wrapping.
- R7: At the edge where either budget reaches zero, `ep_enabled` clears and `xfer_done` is high for exactly one cycle.
- R8: `irq` sets at the edge where `xfer_size` reaches zero while armed. It stays set until an `irq_clear` strobe. If the set and the clear fall in the same cycle, the set wins.
- R9: While armed, `rx_setup` without `rx_commit` lowers a nonzero `pid_field` by one (11 → 10 → 01 → 00) and leaves 00 unchanged. `rx_commit` takes priority over `rx_setup`.
- R10: While disarmed, `rx_commit`, `rx_setup` and `drain_valid` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_load | input | 1 | Software load strobe |
| sw_size | input | 19 | Byte budget to load |
| sw_pkts | input | 10 | Packet budget to load |
| sw_field | input | 2 | Initial PID/setup-count field |
| sw_arm | input | 1 | Software arm strobe |
| rx_commit | input | 1 | Packet committed into receive FIFO |
| rx_pid | input | 2 | Data PID of committed packet |
| rx_setup | input | 1 | SETUP packet received |
| drain_valid | input | 1 | Packet moved from FIFO to memory |
| drain_bytes | input | 11 | Byte count of drained packet |
| irq_clear | input | 1 | Write-one-to-clear for `irq` |
| xfer_size | output | 19 | Remaining byte budget |
| pkt_count | output | 10 | Remaining packet budget |
| pid_field | output | 2 | Last PID or remaining setup count |
| ep_enabled | output | 1 | Endpoint armed |
| xfer_done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky interrupt |

## Verification
The bench targets the following corner cases:

- **Saturating drain.** A drain larger than the remaining bytes must leave `xfer_size` at zero. A design that wrapped would report a huge size and never finish.
- **Completion on the packet budget.** A transfer that ends because the packet budget empties must disarm without raising `irq`. A design that tied the interrupt to every completion would fire it here.
- **Writes while armed.** A load or arm strobe while armed must not change any output. A design with a leaky lock would corrupt a running transfer.
- **Interrupt set against clear.** A clear in the same cycle as a new set must leave `irq` high. Getting this wrong would lose an interrupt.
- **Setup count floor.** The count must stay at zero once there. A design that wrapped would show 11 after a fourth SETUP packet.
- **Arming with an empty budget.** Arming with a zero budget must be ignored. A design that accepted it would produce a spurious done pulse.

// File: rtl/oep_pkg.sv
package oep_pkg;
  localparam int FIELD_W = 2;

  typedef enum logic [FIELD_W-1:0] {
    PID_DATA0 = 2'b00,
    PID_DATA2 = 2'b01,
    PID_DATA1 = 2'b10,
    PID_MDATA = 2'b11
  } data_pid_e;
endpackage

// File: rtl/oep_size_ctr.sv
module oep_size_ctr #(
  parameter int SIZE_W  = 19,
  parameter int BYTES_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] load_val_i,
  input  logic              drain_i,
  input  logic [BYTES_W-1:0] drain_bytes_i,
  output logic [SIZE_W-1:0] size_o,
  output logic [SIZE_W-1:0] size_nxt_o
);
  localparam int PAD_W = SIZE_W - BYTES_W;

  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] size_d;
  logic [SIZE_W-1:0] drain_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign drain_ext = {{PAD_W{1'b0}}, drain_bytes_i};
    end else begin : g_nopad
      assign drain_ext = drain_bytes_i[SIZE_W-1:0];
    end
  endgenerate

  always_comb begin
    size_d = size_q;
    if (!en_i) begin
      if (load_i) size_d = load_val_i;
    end else if (drain_i) begin
      if (drain_ext >= size_q) size_d = '0;
      else                     size_d = size_q - drain_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) size_q <= '0;
    else     size_q <= size_d;
  end

  assign size_o     = size_q;
  assign size_nxt_o = size_d;

  AST_SIZE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en_i && drain_i) |=> (size_q <= $past(size_q))); // R6
  AST_SIZE_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_i) |=> $stable(size_q)); // R10
endmodule

// File: rtl/oep_pkt_ctr.sv
module oep_pkt_ctr
  import oep_pkg::*;
#(
  parameter int PCNT_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [PCNT_W-1:0]  load_cnt_i,
  input  logic [FIELD_W-1:0] load_field_i,
  input  logic               commit_i,
  input  logic [FIELD_W-1:0] pid_i,
  input  logic               setup_i,
  output logic [PCNT_W-1:0]  pcnt_o,
  output logic [PCNT_W-1:0]  pcnt_nxt_o,
  output logic [FIELD_W-1:0] field_o
);
  logic [PCNT_W-1:0]  pcnt_q, pcnt_d;
  logic [FIELD_W-1:0] field_q, field_d;

  always_comb begin
    pcnt_d  = pcnt_q;
    field_d = field_q;
    if (!en_i) begin
      if (load_i) begin
        pcnt_d  = load_cnt_i;
        field_d = load_field_i;
      end
    end else if (commit_i) begin
      if (pcnt_q != '0) pcnt_d = pcnt_q - 1'b1;
      field_d = pid_i;
    end else if (setup_i && field_q != '0) begin
      field_d = field_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q  <= '0;
      field_q <= '0;
    end else begin
      pcnt_q  <= pcnt_d;
      field_q <= field_d;
    end
  end

  assign pcnt_o     = pcnt_q;
  assign pcnt_nxt_o = pcnt_d;
  assign field_o    = field_q;

  AST_PCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_i && commit_i && pcnt_q != '0) |=> (pcnt_q == PCNT_W'($past(pcnt_q) - 1'b1))); // R5
  AST_PID_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (en_i && commit_i) |=> (field_q == $past(pid_i))); // R5
  AST_SETUP_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (en_i && setup_i && !commit_i && field_q == '0) |=> (field_q == '0)); // R9
endmodule

// File: rtl/oep_ctrl.sv
module oep_ctrl #(
  parameter int SIZE_W = 19,
  parameter int PCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic [SIZE_W-1:0] size_nxt_i,
  input  logic [PCNT_W-1:0] pcnt_nxt_i,
  input  logic              irq_clr_i,
  output logic              en_o,
  output logic              done_o,
  output logic              irq_o
);
  logic en_q, done_q, irq_q;
  logic size_empty, pcnt_empty, finish, irq_set;

  assign size_empty = (size_nxt_i == '0);
  assign pcnt_empty = (pcnt_nxt_i == '0);
  assign finish     = en_q && (size_empty || pcnt_empty);
  assign irq_set    = en_q && size_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (en_q)       en_q <= !finish;
      else if (arm_i) en_q <= !size_empty && !pcnt_empty;
      if (irq_set)        irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_DONE_ON_DISARM: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> done_q); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !irq_clr_i) |=> irq_q); // R8
  AST_ARM_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!en_q && arm_i && size_nxt_i == '0) |=> !en_q); // R4
endmodule

// File: rtl/oep_xfer_tracker.sv
module oep_xfer_tracker
  import oep_pkg::*;
#(
  parameter int SIZE_W  = 19,
  parameter int PCNT_W  = 10,
  parameter int BYTES_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_load,
  input  logic [SIZE_W-1:0]  sw_size,
  input  logic [PCNT_W-1:0]  sw_pkts,
  input  logic [FIELD_W-1:0] sw_field,
  input  logic               sw_arm,
  input  logic               rx_commit,
  input  logic [FIELD_W-1:0] rx_pid,
  input  logic               rx_setup,
  input  logic               drain_valid,
  input  logic [BYTES_W-1:0] drain_bytes,
  input  logic               irq_clear,
  output logic [SIZE_W-1:0]  xfer_size,
  output logic [PCNT_W-1:0]  pkt_count,
  output logic [FIELD_W-1:0] pid_field,
  output logic               ep_enabled,
  output logic               xfer_done,
  output logic               irq
);
  logic [SIZE_W-1:0] size_nxt;
  logic [PCNT_W-1:0] pcnt_nxt;
  logic              en;

  oep_size_ctr #(.SIZE_W(SIZE_W), .BYTES_W(BYTES_W)) u_size (
    .clk(clk), .rst(rst), .en_i(en), .load_i(sw_load), .load_val_i(sw_size),
    .drain_i(drain_valid), .drain_bytes_i(drain_bytes),
    .size_o(xfer_size), .size_nxt_o(size_nxt)
  );

  oep_pkt_ctr #(.PCNT_W(PCNT_W)) u_pkt (
    .clk(clk), .rst(rst), .en_i(en), .load_i(sw_load), .load_cnt_i(sw_pkts),
    .load_field_i(sw_field), .commit_i(rx_commit), .pid_i(rx_pid),
    .setup_i(rx_setup), .pcnt_o(pkt_count), .pcnt_nxt_o(pcnt_nxt),
    .field_o(pid_field)
  );

  oep_ctrl #(.SIZE_W(SIZE_W), .PCNT_W(PCNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .arm_i(sw_arm), .size_nxt_i(size_nxt),
    .pcnt_nxt_i(pcnt_nxt), .irq_clr_i(irq_clear),
    .en_o(en), .done_o(xfer_done), .irq_o(irq)
  );

  assign ep_enabled = en;

  AST_LOCKED_WHILE_ARMED: assert property (@(posedge clk) disable iff (rst)
    (en && !drain_valid && !rx_commit) |=> $stable(xfer_size) && $stable(pkt_count)); // R3
endmodule

// File: tb/tb_oep_xfer_tracker.sv
`timescale 1ns/1ps
module tb_oep_xfer_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_load = 0, sw_arm = 0, rx_commit = 0, rx_setup = 0;
  logic        drain_valid = 0, irq_clear = 0;
  logic [18:0] sw_size = '0;
  logic [9:0]  sw_pkts = '0;
  logic [1:0]  sw_field = '0, rx_pid = '0;
  logic [10:0] drain_bytes = '0;
  logic [18:0] xfer_size;
  logic [9:0]  pkt_count;
  logic [1:0]  pid_field;
  logic        ep_enabled, xfer_done, irq;

  int checks = 0;
  int errors = 0;

  logic [18:0] m_size = '0;
  logic [9:0]  m_pcnt = '0;
  logic [1:0]  m_fld = '0;
  logic        m_en = 0, m_done = 0, m_irq = 0;

  always #5 clk = ~clk;

  oep_xfer_tracker dut (
    .clk(clk), .rst(rst), .sw_load(sw_load), .sw_size(sw_size), .sw_pkts(sw_pkts),
    .sw_field(sw_field), .sw_arm(sw_arm), .rx_commit(rx_commit), .rx_pid(rx_pid),
    .rx_setup(rx_setup), .drain_valid(drain_valid), .drain_bytes(drain_bytes),
    .irq_clear(irq_clear), .xfer_size(xfer_size), .pkt_count(pkt_count),
    .pid_field(pid_field), .ep_enabled(ep_enabled), .xfer_done(xfer_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] sat_sub(input logic [18:0] a, input logic [10:0] b);
    return ({8'd0, b} >= a) ? 19'd0 : a - {8'd0, b};
  endfunction

  task automatic compare_all();
    chk("R6 xfer_size", 32'(xfer_size), 32'(m_size));
    chk("R5 pkt_count", 32'(pkt_count), 32'(m_pcnt));
    chk("R5/R9 pid_field", 32'(pid_field), 32'(m_fld));
    chk("R7 ep_enabled", 32'(ep_enabled), 32'(m_en));
    chk("R7 xfer_done", 32'(xfer_done), 32'(m_done));
    chk("R8 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic cyc(input logic ld, input logic ar, input logic cm, input logic dr,
                     input logic su, input logic ck, input logic [18:0] cs,
                     input logic [9:0] cp, input logic [1:0] cf, input logic [1:0] pd,
                     input logic [10:0] nb);
    logic [18:0] ns;
    logic [9:0]  np;
    logic [1:0]  nf;
    logic        ne, nd, ni, fin;
    sw_load = ld; sw_arm = ar; rx_commit = cm; drain_valid = dr; rx_setup = su;
    irq_clear = ck; sw_size = cs; sw_pkts = cp; sw_field = cf; rx_pid = pd;
    drain_bytes = nb;
    ns = m_size; np = m_pcnt; nf = m_fld; ne = m_en; nd = 1'b0; ni = m_irq;
    if (!m_en) begin
      if (ld) begin ns = cs; np = cp; nf = cf; end
      if (ar && ns != 0 && np != 0) ne = 1'b1;
    end else begin
      if (dr) ns = sat_sub(m_size, nb);
      if (cm) begin
        if (np != 0) np = m_pcnt - 10'd1;
        nf = pd;
      end else if (su && nf != 0) nf = m_fld - 2'd1;
      fin = (ns == 0) || (np == 0);
      if (fin) begin ne = 1'b0; nd = 1'b1; end
    end
    if (m_en && ns == 0) ni = 1'b1;
    else if (ck)         ni = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_size = ns; m_pcnt = np; m_fld = nf; m_en = ne; m_done = nd; m_irq = ni;
    sw_load = 0; sw_arm = 0; rx_commit = 0; drain_valid = 0; rx_setup = 0; irq_clear = 0;
    compare_all();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, '0, '0, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0e5d_2a71);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 size", 32'(xfer_size), 0);
    chk("R1 pcnt", 32'(pkt_count), 0);
    chk("R1 field", 32'(pid_field), 0);
    chk("R1 enable", 32'(ep_enabled), 0);
    chk("R1 done", 32'(xfer_done), 0);
    chk("R1 irq", 32'(irq), 0);
    rst = 1'b0;
    idle();

    // R10: traffic while disarmed is ignored
    cyc(0, 0, 1, 1, 1, 0, '0, '0, '0, 2'b11, 11'd7);
    chk("R10 size idle", 32'(xfer_size), 0);
    chk("R10 pcnt idle", 32'(pkt_count), 0);
    // R4: arming with empty budgets ignored
    cyc(0, 1, 0, 0, 0, 0, '0, '0, '0, '0, '0);
    chk("R4 arm empty", 32'(ep_enabled), 0);
    cyc(1, 1, 0, 0, 0, 0, 19'd100, 10'd0, '0, '0, '0);
    chk("R4 arm zero pkts", 32'(ep_enabled), 0);
    // R2: load while idle
    cyc(1, 0, 0, 0, 0, 0, 19'd200, 10'd3, 2'b11, '0, '0);
    chk("R2 size", 32'(xfer_size), 200);
    chk("R2 pcnt", 32'(pkt_count), 3);
    chk("R2 field", 32'(pid_field), 3);
    cyc(0, 1, 0, 0, 0, 0, '0, '0, '0, '0, '0);
    chk("R4 arm ok", 32'(ep_enabled), 1);
    // R3: writes locked while armed
    cyc(1, 1, 0, 0, 0, 0, 19'd5, 10'd9, 2'b00, '0, '0);
    chk("R3 size locked", 32'(xfer_size), 200);
    chk("R3 pcnt locked", 32'(pkt_count), 3);
    chk("R3 field locked", 32'(pid_field), 3);
    // R9: setup count down with floor
    cyc(0, 0, 0, 0, 1, 0, '0, '0, '0, '0, '0);
    chk("R9 setup 3->2", 32'(pid_field), 2);
    cyc(0, 0, 0, 0, 1, 0, '0, '0, '0, '0, '0);
    cyc(0, 0, 0, 0, 1, 0, '0, '0, '0, '0, '0);
    cyc(0, 0, 0, 0, 1, 0, '0, '0, '0, '0, '0);
    chk("R9 setup floor", 32'(pid_field), 0);
    // R5: commit with PID DATA2 (01)
    cyc(0, 0, 1, 0, 1, 0, '0, '0, '0, 2'b01, '0);
    chk("R5 pcnt dec", 32'(pkt_count), 2);
    chk("R5 pid capture", 32'(pid_field), 1);
    // R6: drain and saturate
    cyc(0, 0, 0, 1, 0, 0, '0, '0, '0, '0, 11'd64);
    chk("R6 drain", 32'(xfer_size), 136);
    cyc(0, 0, 0, 1, 0, 0, '0, '0, '0, '0, 11'd200);
    chk("R6 saturate", 32'(xfer_size), 0);
    chk("R7 disarm", 32'(ep_enabled), 0);
    chk("R7 done", 32'(xfer_done), 1);
    chk("R8 irq set", 32'(irq), 1);
    idle();
    chk("R7 done single", 32'(xfer_done), 0);
    chk("R8 irq sticky", 32'(irq), 1);
    cyc(0, 0, 0, 0, 0, 1, '0, '0, '0, '0, '0);
    chk("R8 irq clear", 32'(irq), 0);
    // R7: completion on packet budget, no irq
    cyc(1, 1, 0, 0, 0, 0, 19'd500, 10'd1, '0, '0, '0);
    cyc(0, 0, 1, 0, 0, 0, '0, '0, '0, 2'b10, '0);
    chk("R7 pkt done", 32'(xfer_done), 1);
    chk("R7 pkt disarm", 32'(ep_enabled), 0);
    chk("R8 no irq on pkt end", 32'(irq), 0);
    // R8: set beats clear
    cyc(1, 1, 0, 0, 0, 0, 19'd10, 10'd5, '0, '0, '0);
    cyc(0, 0, 0, 1, 0, 0, '0, '0, '0, '0, 11'd10);
    cyc(1, 1, 0, 0, 0, 0, 19'd10, 10'd5, '0, '0, '0);
    cyc(0, 0, 0, 1, 0, 1, '0, '0, '0, '0, 11'd10);
    chk("R8 set wins", 32'(irq), 1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
          $urandom_range(0, 4) == 0, $urandom_range(0, 7) == 0,
          19'($urandom_range(0, 300)), 10'($urandom_range(0, 6)),
          2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
          11'($urandom_range(0, 64)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule